// File: doc/BRIEF.md
# Alternating Step Bit Generator

This block produces a pseudo-random bit stream from three maximal-length linear-feedback shift registers. A control register steps on every enabled cycle. The control register's output bit picks which one of two generating registers advances in that cycle, and the other generating register holds its state. The registered output bit is the XOR of the two generating registers' output bits.

The feedback polynomial, width and default seed of each register are fixed through parameters when the block is elaborated. A load strobe writes all three seeds in a single cycle. An enable input advances the generator by one step. Each step delivers one output bit, qualified by a valid flag.

Top module: `asg_gen`

## Requirements
- R1: After synchronous reset, `bit_out` and `bit_valid` are 0, and the three registers hold their default seeds (by default control 7'h01, generator A 9'h001, generator B 11'h001).
- R2: Each register steps as a left shift. The new bit 0 is the XOR of the state bits selected by that register's tap mask, and the register's output bit is its most significant bit. The default masks are control 7'h60, A 9'h110 and B 11'h500, all of them primitive.
- R3: The control register steps on every cycle where `en` is 1 and `load` is 0.
- R4: In a stepping cycle where the control output bit is 1, generator A steps and generator B holds.
- R5: In a stepping cycle where the control output bit is 0, generator B steps and generator A holds.
- R6: In the cycle after a stepping cycle, `bit_out` equals the XOR of the MSBs that A and B held before that step.
- R7: `bit_valid` is 1 in the cycle after a stepping cycle and 0 in the cycle after any other cycle.
- R8: When `load` is 1, all three registers take their seeds and no step occurs, even if `en` is 1.
- R9: A seed of all zeros that is loaded into any register puts that register's default seed in its place, so no register ever holds zero.
- R10: `bit_out` keeps its value after any cycle that is not a stepping cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Seed load strobe |
| seed_ctl | input | CTL_W | Seed for the control register |
| seed_a | input | GA_W | Seed for generator A |
| seed_b | input | GB_W | Seed for generator B |
| en | input | 1 | Step enable |
| bit_out | output | 1 | Generated bit |
| bit_valid | output | 1 | Marks `bit_out` as a fresh bit |

## Verification
A step decided at one rising edge appears on `bit_out` and `bit_valid` at that same edge, so each result can be read during the cycle that follows the cycle whose inputs caused it. Loads and non-stepping cycles change the flag at that same edge. The bench drives inputs and samples outputs on falling edges. After each sample it advances a model of the three registers by exactly one cycle using the inputs it has just applied, so every comparison lines up with a single edge. Directed phases cover reset, zero seeds, a load that collides with enable, and seeds whose control MSB forces each branch. Random runs of enable and load follow.

// File: rtl/asg_pkg.sv
package asg_pkg;

    localparam int MAX_W = 32;

    typedef struct packed {
        logic ctl;
        logic ga;
        logic gb;
    } asg_bits_t;

    typedef enum logic {
        SEL_B = 1'b0,
        SEL_A = 1'b1
    } asg_sel_e;

    function automatic logic [MAX_W-1:0] fib_step(
        input logic [MAX_W-1:0] s,
        input logic [MAX_W-1:0] taps,
        input int               w
    );
        logic             fb;
        logic [MAX_W-1:0] mask;
        fb   = ^(s & taps);
        mask = (MAX_W'(1) << w) - MAX_W'(1);
        return ((s << 1) | MAX_W'(fb)) & mask;
    endfunction

endpackage

// File: rtl/asg_lfsr.sv
module asg_lfsr
    import asg_pkg::*;
#(
    parameter int           W    = 7,
    parameter logic [W-1:0] TAPS = 7'h60,
    parameter logic [W-1:0] DEF  = 7'h01
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state_o,
    output logic         msb_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] stepped;
    logic [W-1:0] seed_fix;

    always_comb begin
        stepped  = W'(fib_step(MAX_W'(state_q), MAX_W'(TAPS), W));
        seed_fix = (seed == '0) ? DEF : seed;
    end

    always_ff @(posedge clk) begin
        if (rst)       state_q <= DEF;
        else if (load) state_q <= seed_fix;
        else if (step) state_q <= stepped;
    end

    assign state_o = state_q;
    assign msb_o   = state_q[W-1];

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0) else $error("register reached zero"); // R9
    AST_ZERO_SEED_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> state_q == DEF) else $error("zero seed kept"); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(state_q)) else $error("idle register moved"); // R4
endmodule

// File: rtl/asg_out_stage.sv
module asg_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic bit_a,
    input  logic bit_b,
    output logic bit_out,
    output logic bit_valid
);
    logic out_q;
    logic vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= adv;
            if (adv) out_q <= bit_a ^ bit_b;
        end
    end

    assign bit_out   = out_q;
    assign bit_valid = vld_q;

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(out_q)) else $error("output moved while idle"); // R10
    AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        adv |=> vld_q) else $error("valid missing"); // R7
endmodule

// File: rtl/asg_gen.sv
module asg_gen
    import asg_pkg::*;
#(
    parameter int              CTL_W    = 7,
    parameter int              GA_W     = 9,
    parameter int              GB_W     = 11,
    parameter logic [CTL_W-1:0] CTL_TAPS = 7'h60,
    parameter logic [GA_W-1:0]  GA_TAPS  = 9'h110,
    parameter logic [GB_W-1:0]  GB_TAPS  = 11'h500,
    parameter logic [CTL_W-1:0] CTL_DEF  = 7'h01,
    parameter logic [GA_W-1:0]  GA_DEF   = 9'h001,
    parameter logic [GB_W-1:0]  GB_DEF   = 11'h001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CTL_W-1:0] seed_ctl,
    input  logic [GA_W-1:0]  seed_a,
    input  logic [GB_W-1:0]  seed_b,
    input  logic             en,
    output logic             bit_out,
    output logic             bit_valid
);
    asg_bits_t        msbs;
    asg_sel_e         sel;
    logic             adv;
    logic [CTL_W-1:0] ctl_state;
    logic [GA_W-1:0]  ga_state;
    logic [GB_W-1:0]  gb_state;

    assign adv = en && !load;
    assign sel = asg_sel_e'(msbs.ctl);

    asg_lfsr #(.W(CTL_W), .TAPS(CTL_TAPS), .DEF(CTL_DEF)) u_ctl (
        .clk(clk), .rst(rst), .load(load), .seed(seed_ctl),
        .step(adv), .state_o(ctl_state), .msb_o(msbs.ctl)
    );

    asg_lfsr #(.W(GA_W), .TAPS(GA_TAPS), .DEF(GA_DEF)) u_ga (
        .clk(clk), .rst(rst), .load(load), .seed(seed_a),
        .step(adv && sel == SEL_A), .state_o(ga_state), .msb_o(msbs.ga)
    );

    asg_lfsr #(.W(GB_W), .TAPS(GB_TAPS), .DEF(GB_DEF)) u_gb (
        .clk(clk), .rst(rst), .load(load), .seed(seed_b),
        .step(adv && sel == SEL_B), .state_o(gb_state), .msb_o(msbs.gb)
    );

    asg_out_stage u_out (
        .clk(clk), .rst(rst), .adv(adv),
        .bit_a(msbs.ga), .bit_b(msbs.gb),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    AST_CTL_STEPS: assert property (@(posedge clk) disable iff (rst)
        adv |=> ctl_state != $past(ctl_state)) else $error("control did not step"); // R3
    AST_ONE_GEN_MOVES: assert property (@(posedge clk) disable iff (rst)
        adv |=> ((ga_state != $past(ga_state)) != (gb_state != $past(gb_state))))
        else $error("generators not alternating"); // R5
    AST_LOAD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        load |=> !bit_valid) else $error("valid after load"); // R8
endmodule

// File: tb/asg_gen_tb.sv
module asg_gen_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic        en = 1'b0;
    logic [6:0]  seed_ctl = '0;
    logic [8:0]  seed_a = '0;
    logic [10:0] seed_b = '0;
    logic        bit_out;
    logic        bit_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [6:0]  m_ctl;
    logic [8:0]  m_a;
    logic [10:0] m_b;
    logic        m_out;
    logic        m_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    asg_gen u_dut (
        .clk(clk), .rst(rst), .load(load), .seed_ctl(seed_ctl),
        .seed_a(seed_a), .seed_b(seed_b), .en(en),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s, input logic [31:0] t, input int w);
        logic b;
        b = ^(s & t);
        return ((s << 1) | {31'd0, b}) & ((32'd1 << w) - 32'd1);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // model advance for one edge with the inputs now applied
    task automatic model_edge(input logic ld, input logic e,
                              input logic [6:0] sc, input logic [8:0] sa, input logic [10:0] sb);
        if (ld) begin
            m_ctl = (sc == 0) ? 7'h01 : sc;
            m_a   = (sa == 0) ? 9'h001 : sa;
            m_b   = (sb == 0) ? 11'h001 : sb;
            m_vld = 1'b0;
        end else if (e) begin
            m_out = m_a[8] ^ m_b[10];
            m_vld = 1'b1;
            if (m_ctl[6]) m_a = 9'(nxt(32'(m_a), 32'h110, 9));
            else          m_b = 11'(nxt(32'(m_b), 32'h500, 11));
            m_ctl = 7'(nxt(32'(m_ctl), 32'h60, 7));
        end else begin
            m_vld = 1'b0;
        end
    endtask

    task automatic cyc(input string tag, input logic ld, input logic e,
                       input logic [6:0] sc, input logic [8:0] sa, input logic [10:0] sb);
        load = ld; en = e; seed_ctl = sc; seed_a = sa; seed_b = sb;
        model_edge(ld, e, sc, sa, sb);
        @(negedge clk);
        check({tag, " valid"}, bit_valid, m_vld);
        check({tag, " out"}, bit_out, m_out);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ctl = 7'h01; m_a = 9'h001; m_b = 11'h001; m_out = 1'b0; m_vld = 1'b0;
        check("R1 reset valid", bit_valid, 1'b0);
        check("R1 reset out", bit_out, 1'b0);
        // R1/R2: stream from default seeds
        for (int i = 0; i < 40; i++) cyc("R1 R2 default stream", 1'b0, 1'b1, 0, 0, 0);
        // R9: zero seeds replaced by defaults
        cyc("R9 zero load", 1'b1, 1'b0, 7'h00, 9'h000, 11'h000);
        for (int i = 0; i < 20; i++) cyc("R9 stream after zero seed", 1'b0, 1'b1, 0, 0, 0);
        // R4: control MSB 1 -> A steps
        cyc("R4 load", 1'b1, 1'b0, 7'h40, 9'h100, 11'h001);
        cyc("R4 step A", 1'b0, 1'b1, 0, 0, 0);
        cyc("R4 next", 1'b0, 1'b1, 0, 0, 0);
        // R5: control MSB 0 -> B steps
        cyc("R5 load", 1'b1, 1'b0, 7'h01, 9'h001, 11'h400);
        cyc("R5 step B", 1'b0, 1'b1, 0, 0, 0);
        cyc("R5 next", 1'b0, 1'b1, 0, 0, 0);
        // R8: load with enable takes priority
        cyc("R8 load over enable", 1'b1, 1'b1, 7'h2a, 9'h155, 11'h3c3);
        for (int i = 0; i < 10; i++) cyc("R8 stream after load", 1'b0, 1'b1, 0, 0, 0);
        // R10 / R7: idle cycles keep the bit, drop valid
        for (int i = 0; i < 4; i++) cyc("R10 R7 idle", 1'b0, 1'b0, 0, 0, 0);
        // R3 R6: random mix
        for (int i = 0; i < 3000; i++) begin
            logic ld, e;
            ld = ($urandom % 40) == 0;
            e  = ($urandom % 4) != 0;
            cyc("R3 R6 random", ld, e, 7'($urandom), 9'($urandom), 11'($urandom));
        end
        // R1: reset in mid-stream
        rst = 1'b1; load = 1'b0; en = 1'b1;
        @(negedge clk);
        rst = 1'b0; en = 1'b0;
        m_ctl = 7'h01; m_a = 9'h001; m_b = 11'h001; m_out = 1'b0; m_vld = 1'b0;
        check("R1 reset again valid", bit_valid, 1'b0);
        check("R1 reset again out", bit_out, 1'b0);
        for (int i = 0; i < 20; i++) cyc("R1 stream after reset", 1'b0, 1'b1, 0, 0, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule